// File: doc/BRIEF.md
# Partial Variable-Size Inverse Transform

This block is the one-dimensional inverse transform stage of a video residual decoder. Every accepted input beat carries four signed coefficients of one row or column, and the block turns a vector of coefficients into reconstructed samples at four samples per cycle. A mode input selects the 4-point integer inverse DCT, the 4-point integer inverse DST or the 8-point integer inverse DCT. All constant products come from one shift-add network per input lane that is shared by every mode. No general multipliers are used.

The 8-point transform takes two input beats. The block sorts the lanes of each beat into even-index and odd-index coefficients. It accumulates a 4-point even partial result and a 4-by-4 odd matrix product over the two beats, then emits two output beats: the sums (samples 0..3), followed by the differences (samples 4..7). Each output is rounded by a programmable right shift and saturated to 16 bits. The first stage of a two-pass 2-D inverse transform uses this block with a shift between passes. No transpose storage is included.

Top module: `partial_inv_xform`

## Requirements
- R1: With mode code 0 (or the spare code 3), one beat holding x0..x3 in lanes 0..3 (lane i at in_coef bits [16i+15:16i]) produces y[c] = sum over r of C4[r][c]*x[r]. C4 is the integer 4-point DCT basis, with rows {64,64,64,64}, {83,36,-36,-83}, {64,-64,-64,64} and {36,-83,83,-36}. Sample c is in out_sample lane c.
- R2: With mode code 1, one beat produces y[c] = sum over r of S[r][c]*x[r]. S has rows {29,55,74,84}, {74,74,0,-74}, {84,-29,-74,55} and {55,-84,74,-29}.
- R3: With mode code 2, a start beat carrying x0..x3 and then a non-start beat carrying x4..x7 produce the 8-point integer inverse DCT. The basis entry for row r and column c is the integer cosine weight of angle (2c+1)r·π/16, with magnitudes 64, 89, 83, 75, 64, 50, 36 and 18 for angle steps 0..7. The first output beat holds y0..y3 and the next cycle holds y4..y7.
- R4: Each output is (v + 2^(s-1)) >> s with an arithmetic shift, where s is the shift latched with the start beat. Halves round toward positive infinity. With s = 0 the value passes unchanged.
- R5: A rounded value above 32767 or below -32768 is clamped to that bound.
- R6: out_valid rises in the cycle after the final beat of a vector is accepted. out_last is high on the only beat of a 4-point vector and on the second beat of an 8-point vector. out_last is never high without out_valid.
- R7: in_ready is low only in the first output cycle of an 8-point vector. It is high in all other cycles.
- R8: A start beat clears the accumulators. A vector's result does not depend on any earlier vector, even when vectors are sent back to back.
- R9: A beat with in_start low is discarded when no 8-point vector is open. It produces no output.
- R10: After reset, out_valid and out_last are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_start | input | 1 | Beat is the first of a vector |
| in_mode | input | 2 | 0/3 DCT-4, 1 DST-4, 2 DCT-8 (sampled with in_start) |
| in_shift | input | 4 | Output right-shift amount (sampled with in_start) |
| in_coef | input | 64 | Four signed 16-bit coefficients, lane 0 in the low bits |
| out_valid | output | 1 | Output beat present |
| out_last | output | 1 | Final output beat of the vector |
| out_sample | output | 64 | Four saturated signed 16-bit samples, lane 0 in the low bits |

## Verification
The bench checks every basis sign of the three transforms with impulses and mixed-sign vectors. A wrong shift-add constant or a swapped even/odd lane shows up as a wrong sample at that position only. It also checks rounding exactly at one half for positive and negative values, and saturation at both rails. A design that truncates, or wraps instead of clamping, returns off-by-one or sign-flipped samples. Back-to-back 8-point vectors test the ready gap and the accumulator clear. A design that keeps a stale partial sum would corrupt the second vector, and one that did not stall would overwrite results that are still being emitted. A stray non-start beat must leave no trace at the outputs.

// File: rtl/partial_inv_xform.sv
module partial_inv_xform #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int SH_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_start,
  input  logic [1:0]            in_mode,
  input  logic [SH_W-1:0]       in_shift,
  input  logic [4*IN_W-1:0]     in_coef,
  output logic                  out_valid,
  output logic                  out_last,
  output logic [4*OUT_W-1:0]    out_sample
);
  localparam int ACC_W = IN_W + 10;
  localparam int SUM_W = ACC_W + 2;
  localparam logic [1:0] MODE_DST4 = 2'd1;
  localparam logic [1:0] MODE_DCT8 = 2'd2;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  logic [1:0]      mode_q;
  logic [SH_W-1:0] shift_q;
  logic            open_q, hi_q, ov_q, ol_q;
  logic signed [ACC_W-1:0] e_q [4];
  logic signed [ACC_W-1:0] o_q [4];
  logic signed [ACC_W-1:0] ce  [4];
  logic signed [ACC_W-1:0] co  [4];

  logic signed [ACC_W-1:0] p18[4], p29[4], p36[4], p50[4], p55[4], p64[4];
  logic signed [ACC_W-1:0] p74[4], p75[4], p83[4], p84[4], p89[4];

  for (genvar i = 0; i < 4; i++) begin : g_mcm
    logic signed [ACC_W-1:0] x1, x2, x4, x8, x16, x32, x64, s80, s10;
    assign x1  = ACC_W'($signed(in_coef[i*IN_W +: IN_W]));
    assign x2  = x1 <<< 1;
    assign x4  = x1 <<< 2;
    assign x8  = x1 <<< 3;
    assign x16 = x1 <<< 4;
    assign x32 = x1 <<< 5;
    assign x64 = x1 <<< 6;
    assign s80 = x64 + x16;
    assign s10 = x8 + x2;
    assign p64[i] = x64;
    assign p18[i] = x16 + x2;
    assign p36[i] = x32 + x4;
    assign p50[i] = x32 + p18[i];
    assign p74[i] = x64 + s10;
    assign p75[i] = p74[i] + x1;
    assign p83[i] = s80 + x2 + x1;
    assign p84[i] = s80 + x4;
    assign p89[i] = s80 + x8 + x1;
    assign p29[i] = x32 - x2 - x1;
    assign p55[i] = x64 - x8 - x1;
  end

  wire       accept   = in_valid & in_ready;
  wire [1:0] cur_mode = in_start ? in_mode : mode_q;
  wire       beat1    = ~in_start;
  wire       take_new = accept & in_start;
  wire       take_add = accept & ~in_start & open_q;
  wire       fin      = (take_new & (in_mode != MODE_DCT8)) | take_add;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      ce[k] = '0;
      co[k] = '0;
    end
    if (cur_mode == MODE_DCT8) begin
      if (!beat1) begin
        ce[0] = p64[0] + p83[2];  ce[1] = p64[0] + p36[2];
        ce[2] = p64[0] - p36[2];  ce[3] = p64[0] - p83[2];
        co[0] = p89[1] + p75[3];  co[1] = p75[1] - p18[3];
        co[2] = p50[1] - p89[3];  co[3] = p18[1] - p50[3];
      end else begin
        ce[0] = p64[0] + p36[2];  ce[1] = -p64[0] - p83[2];
        ce[2] = p83[2] - p64[0];  ce[3] = p64[0] - p36[2];
        co[0] = p50[1] + p18[3];  co[1] = -p89[1] - p50[3];
        co[2] = p18[1] + p75[3];  co[3] = p75[1] - p89[3];
      end
    end else if (cur_mode == MODE_DST4) begin
      ce[0] = p29[0] + p74[1] + p84[2] + p55[3];
      ce[1] = p55[0] + p74[1] - p29[2] - p84[3];
      ce[2] = p74[0] - p74[2] + p74[3];
      ce[3] = p84[0] - p74[1] + p55[2] - p29[3];
    end else begin
      ce[0] = p64[0] + p64[2] + p83[1] + p36[3];
      ce[1] = p64[0] - p64[2] + p36[1] - p83[3];
      ce[2] = p64[0] - p64[2] - p36[1] + p83[3];
      ce[3] = p64[0] + p64[2] - p83[1] - p36[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      shift_q <= '0;
      open_q  <= 1'b0;
      for (int k = 0; k < 4; k++) begin
        e_q[k] <= '0;
        o_q[k] <= '0;
      end
    end else begin
      if (take_new) begin
        mode_q  <= in_mode;
        shift_q <= in_shift;
        open_q  <= (in_mode == MODE_DCT8);
        for (int k = 0; k < 4; k++) begin
          e_q[k] <= ce[k];
          o_q[k] <= co[k];
        end
      end else if (take_add) begin
        open_q <= 1'b0;
        for (int k = 0; k < 4; k++) begin
          e_q[k] <= e_q[k] + ce[k];
          o_q[k] <= o_q[k] + co[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      hi_q <= 1'b0;
    end else if (fin) begin
      ov_q <= 1'b1;
      ol_q <= (cur_mode != MODE_DCT8);
      hi_q <= 1'b0;
    end else if (ov_q && !ol_q) begin
      ov_q <= 1'b1;
      ol_q <= 1'b1;
      hi_q <= 1'b1;
    end else begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      hi_q <= 1'b0;
    end
  end

  assign in_ready  = ~(ov_q & ~ol_q);
  assign out_valid = ov_q;
  assign out_last  = ol_q;

  logic [SUM_W-1:0] bias;
  assign bias = (SUM_W'(1) << shift_q) >> 1;

  for (genvar k = 0; k < 4; k++) begin : g_out
    logic signed [SUM_W-1:0] v, t;
    assign v = hi_q ? (SUM_W'(e_q[3-k]) - SUM_W'(o_q[3-k]))
                    : (SUM_W'(e_q[k]) + SUM_W'(o_q[k]));
    assign t = (v + $signed(bias)) >>> shift_q;
    assign out_sample[k*OUT_W +: OUT_W] = (t > SAT_HI) ? SAT_HI[OUT_W-1:0] :
                                          (t < SAT_LO) ? SAT_LO[OUT_W-1:0] :
                                          t[OUT_W-1:0];
  end
endmodule

// File: rtl/partial_inv_xform_checker.sv
module partial_inv_xform_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_last
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R6
  AST_OUT_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !($past(out_valid) && !$past(out_last))) |-> $past(in_valid && in_ready)); // R6
  AST_EIGHT_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && out_last)); // R3
  AST_READY_GAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_last)); // R7
  AST_GAP_IS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready); // R7
endmodule

bind partial_inv_xform partial_inv_xform_checker chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_last(out_last)
);

// File: tb/partial_inv_xform_tb_top.sv
module partial_inv_xform_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0;
  logic [1:0] in_mode = '0;
  logic [3:0] in_shift = '0;
  logic [63:0] in_coef = '0;
  logic in_ready, out_valid, out_last;
  logic [63:0] out_sample;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [63:0] cap [16];
  bit capl [16];
  int ncap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  partial_inv_xform dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_mode(in_mode), .in_shift(in_shift), .in_coef(in_coef),
    .out_valid(out_valid), .out_last(out_last), .out_sample(out_sample)
  );

  always @(negedge clk) if (rst_n && out_valid && ncap < 16) begin
    cap[ncap] = out_sample;
    capl[ncap] = out_last;
    ncap++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int c8(input int r, input int c);
    int mag[9] = '{64, 89, 83, 75, 64, 50, 36, 18, 0};
    int m = ((2*c+1)*r) % 32;
    int s = 1;
    if (m > 16) m = 32 - m;
    if (m > 8) begin m = 16 - m; s = -1; end
    return s * mag[m];
  endfunction

  function automatic int sbas(input int r, input int c);
    int t[16] = '{29, 55, 74, 84, 74, 74, 0, -74, 84, -29, -74, 55, 55, -84, 74, -29};
    return t[r*4+c];
  endfunction

  function automatic longint rnd_sat(input longint v, input int s);
    longint t = v;
    if (s > 0) t = (v + (longint'(1) << (s-1))) >>> s;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  function automatic void ref_y(input int mode, input int s, input int x[8], output longint y[8]);
    int n = (mode == 2) ? 8 : 4;
    for (int c = 0; c < 8; c++) begin
      longint acc = 0;
      if (c < n)
        for (int r = 0; r < n; r++) begin
          int w = (mode == 1) ? sbas(r, c) : (n == 8 ? c8(r, c) : c8(2*r, c));
          acc += longint'(w) * x[r];
        end
      y[c] = rnd_sat(acc, s);
    end
  endfunction

  task automatic drive_beat(input bit st, input int mode, input int s, input int x[8], input int off);
    in_valid = 1'b1;
    in_start = st;
    in_mode  = 2'(mode);
    in_shift = 4'(s);
    for (int k = 0; k < 4; k++) in_coef[k*16 +: 16] = 16'(x[off+k]);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b0;
  endtask

  task automatic cmp_beat(input string req, input int idx, input longint y[8], input int b, input bit lst);
    for (int k = 0; k < 4; k++) begin
      longint a = longint'($signed(cap[idx][k*16 +: 16]));
      chk(a == y[b*4+k], req, a, y[b*4+k]);
    end
    chk(capl[idx] == lst, {req, " last"}, capl[idx], lst);
  endtask

  task automatic run_vec(input string req, input int mode, input int s, input int x[8]);
    longint y[8];
    ncap = 0;
    ref_y(mode, s, x, y);
    drive_beat(1'b1, mode, s, x, 0);
    if (mode == 2) begin
      drive_beat(1'b0, mode, s, x, 4);
      chk(out_valid == 1'b1 && in_ready == 1'b0, "R7 ready gap", in_ready, 0);
      @(negedge clk);
      chk(in_ready == 1'b1, "R7 ready back", in_ready, 1);
    end else begin
      chk(out_valid && out_last && in_ready, "R6 valid timing", out_valid, 1);
    end
    repeat (3) @(negedge clk);
    chk(ncap == ((mode == 2) ? 2 : 1), {req, " beats"}, ncap, (mode == 2) ? 2 : 1);
    cmp_beat(req, 0, y, 0, mode != 2);
    if (mode == 2) cmp_beat(req, 1, y, 1, 1'b1);
  endtask

  task automatic t_reset;
    chk(out_valid == 0 && out_last == 0, "R10 outputs idle", out_valid, 0);
    chk(in_ready == 1, "R10 ready", in_ready, 1);
  endtask

  task automatic t_dct4;
    run_vec("R1 dc",      0, 0, '{100, 0, 0, 0, 0, 0, 0, 0});
    run_vec("R1 odd",     0, 0, '{0, 7, 0, -5, 0, 0, 0, 0});
    run_vec("R1 mix",     0, 7, '{-300, 211, 95, -44, 0, 0, 0, 0});
    run_vec("R1 spare3",  3, 2, '{12, -34, 56, -78, 0, 0, 0, 0});
  endtask

  task automatic t_dst4;
    run_vec("R2 imp",  1, 0, '{0, 1, 0, 0, 0, 0, 0, 0});
    run_vec("R2 imp3", 1, 0, '{0, 0, 0, -1, 0, 0, 0, 0});
    run_vec("R2 mix",  1, 7, '{410, -120, 33, 901, 0, 0, 0, 0});
  endtask

  task automatic t_dct8;
    for (int r = 0; r < 8; r++) begin
      int x[8] = '{0, 0, 0, 0, 0, 0, 0, 0};
      x[r] = (r % 2) ? -3 : 5;
      run_vec("R3 impulse", 2, 0, x);
    end
    run_vec("R3 mix", 2, 6, '{512, -77, 300, 41, -260, 18, 99, -403});
  endtask

  task automatic t_round;
    run_vec("R4 half pos",  0, 7, '{1, 0, 0, 0, 0, 0, 0, 0});
    run_vec("R4 half neg",  0, 7, '{-1, 0, 0, 0, 0, 0, 0, 0});
    run_vec("R4 shift15",   2, 15, '{30000, 25000, -20000, 15000, 9000, -8000, 7000, 6000});
  endtask

  task automatic t_sat;
    run_vec("R5 high", 0, 0, '{32767, 0, 32767, 0, 0, 0, 0, 0});
    run_vec("R5 low",  2, 1, '{-32768, -32768, 0, 0, 0, 0, 0, 0});
  endtask

  task automatic t_clear;
    int a[8] = '{1000, 2000, -3000, 400, 50, -60, 700, 8};
    int b[8] = '{-9, 80, -700, 6, 500, -40, 3, 2};
    longint ya[8], yb[8];
    ref_y(2, 3, a, ya);
    ref_y(2, 0, b, yb);
    ncap = 0;
    drive_beat(1'b1, 2, 3, a, 0);
    drive_beat(1'b0, 2, 3, a, 4);
    drive_beat(1'b1, 2, 0, b, 0);
    drive_beat(1'b0, 2, 0, b, 4);
    repeat (4) @(negedge clk);
    chk(ncap == 4, "R8 beat count", ncap, 4);
    cmp_beat("R8 first", 0, ya, 0, 1'b0);
    cmp_beat("R8 first", 1, ya, 1, 1'b1);
    cmp_beat("R8 second", 2, yb, 0, 1'b0);
    cmp_beat("R8 second", 3, yb, 1, 1'b1);
  endtask

  task automatic t_drop;
    int x[8] = '{111, 222, 333, 444, 0, 0, 0, 0};
    ncap = 0;
    drive_beat(1'b0, 2, 0, x, 0);
    repeat (3) @(negedge clk);
    chk(ncap == 0, "R9 stray beat", ncap, 0);
    run_vec("R9 after stray", 0, 0, '{5, 6, 7, 8, 0, 0, 0, 0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dct4();
    t_dst4();
    t_dct8();
    t_round();
    t_sat();
    t_clear();
    t_drop();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule